// File: doc/BRIEF.md
# Byte-Addressed Program Counter with Holding Latches

This block keeps the instruction address of a core that fetches 16-bit instruction words from byte-addressed program memory. The 21-bit counter moves forward by one instruction (two bytes) on each advance strobe. A branch, call or goto loads it directly from a separate load port. Bit 0 is always zero, so the counter can never point into the middle of an instruction word.

Software on the core sees only the low byte of the counter through a small data-bus port. The middle byte and the top bits of the counter cannot be reached directly. Two holding latches, an 8-bit high latch and a 5-bit upper latch, stand in for them. Writing the low byte loads the whole counter at once, taking the upper bits from the latches. Reading the low byte copies the current upper bits into the latches. Computed jumps and reading back the full address both depend on these two side effects.

Top module: `prog_counter_latched`

## Requirements
- R1: After reset the counter output and both latches read zero.
- R2: An advance strobe, with no direct load and no low-byte write in the same cycle, adds 2 to the counter on the next clock edge, and the counter wraps from 0x1FFFFE to 0x000000.
- R3: Bit 0 of the counter output is always zero, even when a load address or low-byte write value has bit 0 set.
- R4: A bus write with select 2'b00 (low byte) sets the counter to {upper latch, high latch, write byte with bit 0 cleared} on the next edge.
- R5: Bus writes with select 2'b01 (high latch), 2'b10 (upper latch) or 2'b11 (unused) leave the counter unchanged.
- R6: A bus read with select 2'b00 returns counter bits 7:0 in the same cycle and, on the next edge, copies counter bits 15:8 into the high latch and bits 20:16 into the upper latch.
- R7: A direct load sets the counter to the load address with bit 0 cleared, and it ignores the latch contents.
- R8: When a direct load and an advance occur in the same cycle, the direct load wins.
- R9: When a low-byte write and an advance occur in the same cycle, the low-byte write wins.
- R10: The upper latch stores write bits 4:0, and a read of it (select 2'b10) returns zeros in bits 7:5.
- R11: Advances and direct loads leave both latches unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_i | input | 1 | Advance by one instruction word |
| ld_i | input | 1 | Direct load strobe |
| ld_addr_i | input | 21 | Direct load target address |
| bus_we_i | input | 1 | Data-bus write strobe |
| bus_re_i | input | 1 | Data-bus read strobe |
| bus_sel_i | input | 2 | Bus register select: 00 low byte, 01 high latch, 10 upper latch, 11 unused |
| bus_wdata_i | input | 8 | Data-bus write byte |
| bus_rdata_o | output | 8 | Data-bus read byte, combinational from the select |
| pc_o | output | 21 | Full counter value |

## Verification
The bench builds the block with its default 21-bit width, which places the 5-bit upper latch and its three zero read-back bits on real bit positions. The wrap boundary cannot be reached by stepping through two million addresses. The bench reaches it by direct-loading 0x1FFFFE and then advancing once. At this width a single low-byte write with odd data and full latches also sets every bit of the counter except bit 0, which must stay zero.

// File: rtl/pc_pkg.sv
package pc_pkg;
  parameter int PC_W   = 21;
  parameter int BYTE_W = 8;
  localparam int UP_W  = PC_W - 2 * BYTE_W;
  localparam int HI_LO = BYTE_W;
  localparam int UP_LO = 2 * BYTE_W;

  typedef logic [PC_W-1:0]   pc_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [UP_W-1:0]   up_t;

  typedef enum logic [1:0] {
    SEL_LOW  = 2'b00,
    SEL_HIGH = 2'b01,
    SEL_UP   = 2'b10,
    SEL_NONE = 2'b11
  } bus_sel_e;

  // Clear the byte-within-word bit.
  function automatic pc_t pc_align(input pc_t a);
    pc_t r;
    r = a;
    r[0] = 1'b0;
    return r;
  endfunction

  // One instruction word forward, modulo the address space.
  function automatic pc_t pc_step(input pc_t a);
    return pc_align(a + pc_t'(2));
  endfunction

  // Full address assembled from the latches and a low byte.
  function automatic pc_t pc_from_latches(input up_t up, input byte_t hi, input byte_t lo);
    return pc_align({up, hi, lo});
  endfunction
endpackage

// File: rtl/pc_bus_decode.sv
module pc_bus_decode
  import pc_pkg::*;
(
  input  logic       bus_we_i,
  input  logic       bus_re_i,
  input  logic [1:0] bus_sel_i,
  output logic       low_wr_o,
  output logic       low_rd_o,
  output logic       hi_wr_o,
  output logic       up_wr_o
);
  always_comb begin
    low_wr_o = 1'b0;
    low_rd_o = 1'b0;
    hi_wr_o  = 1'b0;
    up_wr_o  = 1'b0;
    unique case (bus_sel_e'(bus_sel_i))
      SEL_LOW: begin
        low_wr_o = bus_we_i;
        low_rd_o = bus_re_i;
      end
      SEL_HIGH: hi_wr_o = bus_we_i;
      SEL_UP:   up_wr_o = bus_we_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/pc_latch_bank.sv
module pc_latch_bank
  import pc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  low_rd_i,
  input  logic  hi_wr_i,
  input  logic  up_wr_i,
  input  byte_t wdata_i,
  input  byte_t pc_hi_i,
  input  up_t   pc_up_i,
  output byte_t hi_q_o,
  output up_t   up_q_o
);
  byte_t hi_q;
  up_t   up_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      up_q <= '0;
    end else begin
      if (low_rd_i)     hi_q <= pc_hi_i;
      else if (hi_wr_i) hi_q <= wdata_i;
      if (low_rd_i)     up_q <= pc_up_i;
      else if (up_wr_i) up_q <= wdata_i[UP_W-1:0];
    end
  end

  assign hi_q_o = hi_q;
  assign up_q_o = up_q;

  // R6: reading the low byte refreshes both latches from the counter
  a_r6_read_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    low_rd_i |=> (hi_q == $past(pc_hi_i)) && (up_q == $past(pc_up_i)));
  // R11: latches hold unless touched through the bus
  a_r11_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!low_rd_i && !hi_wr_i && !up_wr_i) |=> $stable(hi_q) && $stable(up_q));
  // R10: upper latch keeps only its low write bits
  a_r10_up_write: assert property (@(posedge clk) disable iff (!rst_n)
    (up_wr_i && !low_rd_i) |=> up_q == $past(wdata_i[UP_W-1:0]));
endmodule

// File: rtl/pc_count_reg.sv
module pc_count_reg
  import pc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv_i,
  input  logic  ld_i,
  input  pc_t   ld_addr_i,
  input  logic  low_wr_i,
  input  byte_t wdata_i,
  input  byte_t hi_q_i,
  input  up_t   up_q_i,
  output pc_t   pc_o
);
  pc_t pc_q;
  pc_t pc_d;
  pc_t pc_next_seq;
  pc_t pc_next_bus;
  pc_t pc_next_ld;

  assign pc_next_seq = pc_step(pc_q);
  assign pc_next_bus = pc_from_latches(up_q_i, hi_q_i, wdata_i);
  assign pc_next_ld  = pc_align(ld_addr_i);

  // Priority: direct load, then low-byte write, then advance.
  always_comb begin
    pc_d = pc_q;
    if (ld_i)          pc_d = pc_next_ld;
    else if (low_wr_i) pc_d = pc_next_bus;
    else if (adv_i)    pc_d = pc_next_seq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  // R8 / R7: direct load wins and ignores the latches
  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> pc_q == pc_align($past(ld_addr_i)));
  // R2: advance moves forward one word
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !ld_i && !low_wr_i) |=> pc_q == $past(pc_q) + pc_t'(2));
  // R4 / R9: low-byte write transfers the latches
  a_r4_low_write: assert property (@(posedge clk) disable iff (!rst_n)
    (low_wr_i && !ld_i) |=> pc_q[PC_W-1:BYTE_W] == $past({up_q_i, hi_q_i}));
  // R5: nothing requested, nothing changes
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !ld_i && !low_wr_i) |=> $stable(pc_q));
endmodule

// File: rtl/prog_counter_latched.sv
module prog_counter_latched
  import pc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              ld_i,
  input  logic [PC_W-1:0]   ld_addr_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [1:0]        bus_sel_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  output logic [PC_W-1:0]   pc_o
);
  logic  low_wr_evt;
  logic  low_rd_evt;
  logic  hi_wr_evt;
  logic  up_wr_evt;
  byte_t hi_q;
  up_t   up_q;
  pc_t   pc_q;

  pc_bus_decode u_dec (
    .bus_we_i (bus_we_i),
    .bus_re_i (bus_re_i),
    .bus_sel_i(bus_sel_i),
    .low_wr_o (low_wr_evt),
    .low_rd_o (low_rd_evt),
    .hi_wr_o  (hi_wr_evt),
    .up_wr_o  (up_wr_evt)
  );

  pc_latch_bank u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .low_rd_i(low_rd_evt),
    .hi_wr_i (hi_wr_evt),
    .up_wr_i (up_wr_evt),
    .wdata_i (bus_wdata_i),
    .pc_hi_i (pc_q[UP_LO-1:HI_LO]),
    .pc_up_i (pc_q[PC_W-1:UP_LO]),
    .hi_q_o  (hi_q),
    .up_q_o  (up_q)
  );

  pc_count_reg u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_i    (adv_i),
    .ld_i     (ld_i),
    .ld_addr_i(ld_addr_i),
    .low_wr_i (low_wr_evt),
    .wdata_i  (bus_wdata_i),
    .hi_q_i   (hi_q),
    .up_q_i   (up_q),
    .pc_o     (pc_q)
  );

  always_comb begin
    unique case (bus_sel_e'(bus_sel_i))
      SEL_LOW:  bus_rdata_o = pc_q[BYTE_W-1:0];
      SEL_HIGH: bus_rdata_o = hi_q;
      SEL_UP:   bus_rdata_o = byte_t'(up_q);
      default:  bus_rdata_o = '0;
    endcase
  end

  assign pc_o = pc_q;

  // R3: output always word-aligned
  a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n) pc_o[0] == 1'b0);
  // R10: unused upper-latch bits read as zero
  a_r10_up_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i == 2'b10) |-> bus_rdata_o[BYTE_W-1:UP_W] == '0);
endmodule

// File: tb/prog_counter_latched_bench.sv
module prog_counter_latched_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv_i = 1'b0;
  logic        ld_i = 1'b0;
  logic [20:0] ld_addr_i = '0;
  logic        bus_we_i = 1'b0;
  logic        bus_re_i = 1'b0;
  logic [1:0]  bus_sel_i = 2'b00;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic [20:0] pc_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prog_counter_latched u_prog_counter_latched (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .ld_i(ld_i), .ld_addr_i(ld_addr_i),
    .bus_we_i(bus_we_i), .bus_re_i(bus_re_i), .bus_sel_i(bus_sel_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .pc_o(pc_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    adv_i = 0; ld_i = 0; bus_we_i = 0; bus_re_i = 0; bus_sel_i = 2'b11;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] v);
    bus_sel_i = sel;
    #1;
    v = bus_rdata_o;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d, input logic with_adv);
    bus_sel_i = sel; bus_wdata_i = d; bus_we_i = 1; adv_i = with_adv;
    tick();
    idle();
  endtask

  task automatic load(input logic [20:0] a, input logic with_adv);
    ld_addr_i = a; ld_i = 1; adv_i = with_adv;
    tick();
    idle();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 pc", pc_o, 0);
    rd(2'b01, v); chk("R1 high latch", v, 0);
    rd(2'b10, v); chk("R1 upper latch", v, 0);
  endtask

  task automatic t_advance();
    for (int i = 0; i < 3; i++) begin adv_i = 1; tick(); end
    idle();
    chk("R2 three advances", pc_o, 21'h6);
  endtask

  task automatic t_latch_writes();
    logic [7:0] v;
    wr(2'b01, 8'h12, 0);
    chk("R5 high latch write", pc_o, 21'h6);
    wr(2'b10, 8'hFF, 0);
    chk("R5 upper latch write", pc_o, 21'h6);
    wr(2'b11, 8'hAA, 0);
    chk("R5 unused select write", pc_o, 21'h6);
    rd(2'b01, v); chk("R5 high latch value", v, 8'h12);
    rd(2'b10, v); chk("R10 upper readback", v, 8'h1F);
  endtask

  task automatic t_low_write();
    wr(2'b00, 8'h35, 0);
    chk("R4 R3 low write transfer", pc_o, 21'h1F1234);
    wr(2'b00, 8'hFF, 0);
    chk("R3 all-ones low write", pc_o, 21'h1F12FE);
  endtask

  task automatic t_load();
    logic [7:0] v;
    load(21'h0ABCDF, 0);
    chk("R7 R3 direct load", pc_o, 21'h0ABCDE);
    rd(2'b01, v); chk("R11 high latch after load", v, 8'h12);
    rd(2'b10, v); chk("R11 upper latch after load", v, 8'h1F);
    load(21'h000100, 1);
    chk("R8 load beats advance", pc_o, 21'h000100);
  endtask

  task automatic t_read_refresh();
    logic [7:0] v;
    load(21'h154320, 0);
    bus_sel_i = 2'b00; bus_re_i = 1;
    #1;
    chk("R6 low byte read value", bus_rdata_o, 8'h20);
    tick();
    idle();
    rd(2'b01, v); chk("R6 high latch refreshed", v, 8'h43);
    rd(2'b10, v); chk("R6 upper latch refreshed", v, 8'h15);
    chk("R6 read leaves pc", pc_o, 21'h154320);
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    load(21'h1FFFFE, 0);
    adv_i = 1; tick(); idle();
    chk("R2 wrap to zero", pc_o, 0);
    rd(2'b01, v); chk("R11 high latch after advances", v, 8'h43);
  endtask

  task automatic t_write_vs_adv();
    wr(2'b01, 8'h00, 0);
    wr(2'b10, 8'hE1, 0);
    wr(2'b00, 8'h80, 1);
    chk("R9 low write beats advance", pc_o, 21'h010080);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    tick(); tick();
    rst_n = 1;
    tick();
    t_reset();
    t_advance();
    t_latch_writes();
    t_low_write();
    t_load();
    t_read_refresh();
    t_wrap();
    t_write_vs_adv();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule